// File: doc/BRIEF.md
# Multiplexed External Bus Interface

This block links an internal 16-bit memory request port to two 8-bit external pin ports, an upper port and a lower port. Each pin has its own output value, output enable and input. Which job the ports do depends on an operating mode. The block samples the mode from a two-bit mode-select input while reset is held. After reset is released, the mode stays fixed.

In single-chip mode the ports are plain general-purpose I/O. Each port has a data register and a direction register, and the block runs no bus cycles. In the wide expanded mode, one bus cycle carries a full 16-bit address and then 16 bits of data across both ports. In the narrow expanded mode, both ports present the 16-bit address, and data moves one byte at a time on the upper port only. A 16-bit access in narrow mode therefore becomes two ordered byte cycles: the high byte first, and then the low byte at the next address.

Every bus cycle has one address-phase clock, marked by an address strobe, followed by one data-phase clock. A read/write level is held valid across both phases. The requester learns that the access is complete from a one-clock ready pulse. For reads, the assembled word is returned with that pulse.

Top module: `mxbus_if`

## Requirements
- R1: The mode is captured from `mode_sel` during every clock in which `rst` is high, and changes of `mode_sel` while `rst` is low have no effect. The encoding is: bit 1 low selects single-chip; `2'b10` selects narrow; `2'b11` selects wide.
- R2: In single-chip mode, the data registers drive `pa_out`/`pb_out` and the direction registers drive `pa_oe`/`pb_oe`. These registers are written through `gp_we` with `gp_sel` set as follows: 0 for upper data, 1 for upper direction, 2 for lower data, 3 for lower direction. The registers reset to zero. Requests are ignored: the address strobe never rises and ready never pulses.
- R3: A bus cycle is one clock with `bus_as` high (address phase) followed by one clock with `bus_as` low (data phase). `bus_rnw` equals the inverse of `req_write` over both phases and is 1 at all other times.
- R4: In the address phase of both expanded modes, `pa_out` shows address bits 15:8 and `pb_out` shows address bits 7:0, with both ports fully enabled.
- R5: For a wide 16-bit write, the data phase drives `req_wdata[15:8]` on the upper port and `req_wdata[7:0]` on the lower port. For a wide 16-bit read, both ports are released during the data phase, and `rsp_rdata` returns `{pa_in, pb_in}` as sampled at the end of that phase.
- R6: A wide 8-bit access uses the upper port when address bit 0 is 0 and the lower port when it is 1. Write data comes from `req_wdata[7:0]` and the unused port is released. Read data is returned in `rsp_rdata[7:0]`, with bits 15:8 set to zero.
- R7: In the narrow data phase, the lower port keeps driving address bits 7:0 and the upper port carries the data byte. The upper port is driven on writes and released on reads.
- R8: A narrow 16-bit access runs two bus cycles. The first uses the request address and carries data bits 15:8. The second uses the request address plus one (16-bit wraparound) and carries bits 7:0. A read returns `{first byte, second byte}`.
- R9: A narrow 8-bit access runs a single bus cycle carrying `req_wdata[7:0]`. A read returns `{8'h00, byte}`.
- R10: `req_ready` is high for exactly the one clock that follows the last data phase and is low at every other time.
- R11: In an expanded mode, when no bus cycle is in progress, both ports are released (all output enables low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; mode is sampled while high |
| mode_sel | input | 2 | Operating mode select |
| req_valid | input | 1 | Request present; held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size16 | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| req_addr | input | 16 | Request byte address |
| req_wdata | input | 16 | Write data (8-bit access uses bits 7:0) |
| req_ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, valid with ready |
| gp_we | input | 1 | General-purpose register write strobe |
| gp_sel | input | 2 | Register select for the strobe |
| gp_wdata | input | 8 | Register write value |
| pa_in | input | 8 | Upper port pin inputs |
| pa_out | output | 8 | Upper port pin outputs |
| pa_oe | output | 8 | Upper port output enables |
| pb_in | input | 8 | Lower port pin inputs |
| pb_out | output | 8 | Lower port pin outputs |
| pb_oe | output | 8 | Lower port output enables |
| bus_as | output | 1 | Address strobe |
| bus_rnw | output | 1 | Read (1) / write (0) level |

## Verification
The bench aims at the seams between the two byte cycles of a narrow 16-bit access. A design that got this wrong would swap the two bytes, would reuse the first address instead of adding one, or would fail to wrap from 0xFFFF to 0x0000. Wide byte accesses go to both lanes, which catches a design that inverts the address-bit-0 lane choice or leaves the idle port driven. After reset, mode-select is deliberately changed, so a design that keeps re-sampling the mode would switch pin mappings in the middle of a test. In single-chip mode, requests are applied to show that a design which runs bus cycles there, or lets the bus override the I/O registers, is detected.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_NARROW = 2'd1,
        MODE_WIDE   = 2'd2
    } bus_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    typedef struct packed {
        logic write;
        logic size16;
    } req_kind_t;

    function automatic bus_mode_e decode_mode(input logic [1:0] sel);
        if (!sel[1])
            return MODE_SINGLE;
        else if (sel[0])
            return MODE_WIDE;
        else
            return MODE_NARROW;
    endfunction

endpackage

// File: rtl/mxb_mode_latch.sv
module mxb_mode_latch
    import mxb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    output bus_mode_e  mode
);
    always_ff @(posedge clk) begin
        if (rst)
            mode <= decode_mode(mode_sel);
    end
endmodule

// File: rtl/mxb_gpio.sv
module mxb_gpio #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] a_dat,
    output logic [PORT_W-1:0] a_dir,
    output logic [PORT_W-1:0] b_dat,
    output logic [PORT_W-1:0] b_dir
);
    localparam int NPORT = 2;

    logic [PORT_W-1:0] dat_q [NPORT];
    logic [PORT_W-1:0] dir_q [NPORT];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                dat_q[p] <= '0;
                dir_q[p] <= '0;
            end else if (we && sel[1] == 1'(p)) begin
                if (sel[0])
                    dir_q[p] <= wdata;
                else
                    dat_q[p] <= wdata;
            end
        end
    end

    assign a_dat = dat_q[0];
    assign a_dir = dir_q[0];
    assign b_dat = dat_q[1];
    assign b_dir = dir_q[1];
endmodule

// File: rtl/mxb_seq.sv
module mxb_seq
    import mxb_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  bus_mode_e           mode,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_size16,
    input  logic [2*PORT_W-1:0] req_addr,
    input  logic [2*PORT_W-1:0] req_wdata,
    input  logic [PORT_W-1:0]   pa_in,
    input  logic [PORT_W-1:0]   pb_in,
    output phase_e              phase,
    output logic [2*PORT_W-1:0] cur_addr,
    output logic                beat,
    output req_kind_t           kind,
    output logic [2*PORT_W-1:0] wdata_q,
    output logic                req_ready,
    output logic [2*PORT_W-1:0] rsp_rdata
);
    localparam int WORD_W = 2 * PORT_W;

    logic [PORT_W-1:0] hi_q;
    logic [WORD_W-1:0] rdata_q;
    logic [WORD_W-1:0] assembled;
    logic              split_more;

    assign split_more = (mode == MODE_NARROW) && kind.size16 && !beat;

    always_comb begin
        if (mode == MODE_WIDE) begin
            if (kind.size16)
                assembled = {pa_in, pb_in};
            else
                assembled = {{PORT_W{1'b0}}, cur_addr[0] ? pb_in : pa_in};
        end else begin
            if (kind.size16)
                assembled = {hi_q, pa_in};
            else
                assembled = {{PORT_W{1'b0}}, pa_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cur_addr <= '0;
            beat     <= 1'b0;
            kind     <= '0;
            wdata_q  <= '0;
            hi_q     <= '0;
            rdata_q  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid && mode != MODE_SINGLE) begin
                        phase    <= PH_ADDR;
                        cur_addr <= req_addr;
                        kind     <= '{write: req_write, size16: req_size16};
                        wdata_q  <= req_wdata;
                        beat     <= 1'b0;
                    end
                end
                PH_ADDR: phase <= PH_DATA;
                PH_DATA: begin
                    if (split_more) begin
                        beat     <= 1'b1;
                        cur_addr <= cur_addr + WORD_W'(1);
                        hi_q     <= pa_in;
                        phase    <= PH_ADDR;
                    end else begin
                        phase <= PH_DONE;
                        if (!kind.write)
                            rdata_q <= assembled;
                    end
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign req_ready = (phase == PH_DONE);
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/mxb_pinmux.sv
module mxb_pinmux
    import mxb_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  bus_mode_e           mode,
    input  phase_e              phase,
    input  logic [2*PORT_W-1:0] cur_addr,
    input  logic                beat,
    input  req_kind_t           kind,
    input  logic [2*PORT_W-1:0] wdata_q,
    input  logic [PORT_W-1:0]   gp_a_dat,
    input  logic [PORT_W-1:0]   gp_a_dir,
    input  logic [PORT_W-1:0]   gp_b_dat,
    input  logic [PORT_W-1:0]   gp_b_dir,
    output logic [PORT_W-1:0]   pa_out,
    output logic [PORT_W-1:0]   pa_oe,
    output logic [PORT_W-1:0]   pb_out,
    output logic [PORT_W-1:0]   pb_oe,
    output logic                bus_as,
    output logic                bus_rnw
);
    localparam int WORD_W = 2 * PORT_W;
    localparam logic [PORT_W-1:0] ALL_ON = {PORT_W{1'b1}};

    logic [PORT_W-1:0] ad_hi, ad_lo, wd_hi, wd_lo;

    assign ad_hi = cur_addr[WORD_W-1:PORT_W];
    assign ad_lo = cur_addr[PORT_W-1:0];
    assign wd_hi = wdata_q[WORD_W-1:PORT_W];
    assign wd_lo = wdata_q[PORT_W-1:0];

    always_comb begin
        pa_out = '0;
        pa_oe  = '0;
        pb_out = '0;
        pb_oe  = '0;
        if (mode == MODE_SINGLE) begin
            pa_out = gp_a_dat;
            pa_oe  = gp_a_dir;
            pb_out = gp_b_dat;
            pb_oe  = gp_b_dir;
        end else if (phase == PH_ADDR) begin
            pa_out = ad_hi;
            pa_oe  = ALL_ON;
            pb_out = ad_lo;
            pb_oe  = ALL_ON;
        end else if (phase == PH_DATA) begin
            if (mode == MODE_WIDE) begin
                if (kind.write) begin
                    if (kind.size16) begin
                        pa_out = wd_hi;
                        pa_oe  = ALL_ON;
                        pb_out = wd_lo;
                        pb_oe  = ALL_ON;
                    end else if (!cur_addr[0]) begin
                        pa_out = wd_lo;
                        pa_oe  = ALL_ON;
                    end else begin
                        pb_out = wd_lo;
                        pb_oe  = ALL_ON;
                    end
                end
            end else begin
                pb_out = ad_lo;
                pb_oe  = ALL_ON;
                if (kind.write) begin
                    pa_out = (kind.size16 && !beat) ? wd_hi : wd_lo;
                    pa_oe  = ALL_ON;
                end
            end
        end
    end

    assign bus_as  = (mode != MODE_SINGLE) && (phase == PH_ADDR);
    assign bus_rnw = ((phase == PH_ADDR) || (phase == PH_DATA)) ? !kind.write : 1'b1;
endmodule

// File: rtl/mxbus_if.sv
module mxbus_if
    import mxb_pkg::*;
#(
    parameter int PORT_W = 8,
    localparam int WORD_W = 2 * PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_size16,
    input  logic [WORD_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [WORD_W-1:0] rsp_rdata,
    input  logic              gp_we,
    input  logic [1:0]        gp_sel,
    input  logic [PORT_W-1:0] gp_wdata,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic [PORT_W-1:0] pb_oe,
    output logic              bus_as,
    output logic              bus_rnw
);
    bus_mode_e         mode_q;
    phase_e            phase;
    logic [WORD_W-1:0] cur_addr;
    logic              beat;
    req_kind_t         kind;
    logic [WORD_W-1:0] wdata_q;
    logic [PORT_W-1:0] gp_a_dat, gp_a_dir, gp_b_dat, gp_b_dir;

    mxb_mode_latch u_mode (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .mode     (mode_q)
    );

    mxb_gpio #(.PORT_W(PORT_W)) u_gpio (
        .clk   (clk),
        .rst   (rst),
        .we    (gp_we),
        .sel   (gp_sel),
        .wdata (gp_wdata),
        .a_dat (gp_a_dat),
        .a_dir (gp_a_dir),
        .b_dat (gp_b_dat),
        .b_dir (gp_b_dir)
    );

    mxb_seq #(.PORT_W(PORT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_q),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_size16 (req_size16),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .pa_in      (pa_in),
        .pb_in      (pb_in),
        .phase      (phase),
        .cur_addr   (cur_addr),
        .beat       (beat),
        .kind       (kind),
        .wdata_q    (wdata_q),
        .req_ready  (req_ready),
        .rsp_rdata  (rsp_rdata)
    );

    mxb_pinmux #(.PORT_W(PORT_W)) u_pins (
        .mode     (mode_q),
        .phase    (phase),
        .cur_addr (cur_addr),
        .beat     (beat),
        .kind     (kind),
        .wdata_q  (wdata_q),
        .gp_a_dat (gp_a_dat),
        .gp_a_dir (gp_a_dir),
        .gp_b_dat (gp_b_dat),
        .gp_b_dir (gp_b_dir),
        .pa_out   (pa_out),
        .pa_oe    (pa_oe),
        .pb_out   (pb_out),
        .pb_oe    (pb_oe),
        .bus_as   (bus_as),
        .bus_rnw  (bus_rnw)
    );
endmodule

// File: rtl/mxbus_if_chk.sv
module mxbus_if_chk
    import mxb_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input bus_mode_e         mode_q,
    input phase_e            phase,
    input logic              bus_as,
    input logic              bus_rnw,
    input logic              req_ready,
    input logic [PORT_W-1:0] pb_oe
);
    // R10
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);

    // R3
    strobe_then_data_chk: assert property (@(posedge clk) disable iff (rst)
        bus_as |=> (!bus_as && $stable(bus_rnw)));

    // R2
    single_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SINGLE) |-> (!bus_as && !req_ready));

    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(mode_q));

    // R7
    narrow_low_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_NARROW && phase == PH_DATA) |-> (pb_oe == {PORT_W{1'b1}}));
endmodule

bind mxbus_if mxbus_if_chk #(.PORT_W(PORT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_q    (mode_q),
    .phase     (phase),
    .bus_as    (bus_as),
    .bus_rnw   (bus_rnw),
    .req_ready (req_ready),
    .pb_oe     (pb_oe)
);

// File: tb/sim_mxbus_if.sv
`timescale 1ns/1ps
module sim_mxbus_if;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'b00;
    logic        req_valid = 1'b0, req_write = 1'b0, req_size16 = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        req_ready;
    logic [15:0] rsp_rdata;
    logic        gp_we = 1'b0;
    logic [1:0]  gp_sel = '0;
    logic [7:0]  gp_wdata = '0;
    logic [7:0]  pa_in = '0, pb_in = '0;
    logic [7:0]  pa_out, pa_oe, pb_out, pb_oe;
    logic        bus_as, bus_rnw;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mxbus_if u0 (
        .clk(clk), .rst(rst), .mode_sel(mode_sel),
        .req_valid(req_valid), .req_write(req_write), .req_size16(req_size16),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .gp_we(gp_we), .gp_sel(gp_sel), .gp_wdata(gp_wdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .bus_as(bus_as), .bus_rnw(bus_rnw)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input bit nar, input bit s16,
                                             input logic [15:0] ad,
                                             input logic [7:0] a0, input logic [7:0] b0,
                                             input logic [7:0] a1);
        if (!nar)
            return s16 ? {a0, b0} : {8'h00, ad[0] ? b0 : a0};
        else
            return s16 ? {a0, a1} : {8'h00, a0};
    endfunction

    task automatic do_reset(input logic [1:0] m, input logic [1:0] after);
        @(negedge clk);
        rst = 1'b1;
        mode_sel = m;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mode_sel = after;
        @(negedge clk);
    endtask

    task automatic access(input bit nar, input bit wr, input bit s16,
                          input logic [15:0] ad, input logic [15:0] wd);
        int beats;
        logic [15:0] ca;
        logic [7:0] a_rx [2];
        logic [7:0] b_rx [2];
        string mt;
        beats = (nar && s16) ? 2 : 1;
        mt = nar ? "R7" : (s16 ? "R5" : "R6");
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size16 = s16;
        req_addr = ad; req_wdata = wd;
        for (int b = 0; b < beats; b++) begin
            ca = ad + 16'(b);
            @(negedge clk);
            chk("R3 strobe in address phase", {15'd0, bus_as}, 16'd1);
            chk("R3 rnw in address phase", {15'd0, bus_rnw}, {15'd0, !wr});
            chk("R10 no ready mid-access", {15'd0, req_ready}, 16'd0);
            chk(nar && b == 1 ? "R8 second address" : "R4 address on ports",
                {pa_out, pb_out}, ca);
            chk("R4 address enables", {pa_oe, pb_oe}, 16'hFFFF);
            a_rx[b] = 8'($urandom);
            b_rx[b] = 8'($urandom);
            @(negedge clk);
            pa_in = a_rx[b];
            pb_in = b_rx[b];
            chk("R3 strobe low in data phase", {15'd0, bus_as}, 16'd0);
            chk("R3 rnw in data phase", {15'd0, bus_rnw}, {15'd0, !wr});
            if (nar) begin
                chk("R7 lower port holds address", {pb_out, pb_oe}, {ca[7:0], 8'hFF});
                if (wr)
                    chk(s16 ? "R8 byte order" : "R9 narrow byte", {pa_out, pa_oe},
                        {(s16 && b == 0) ? wd[15:8] : wd[7:0], 8'hFF});
                else
                    chk("R7 upper released on read", {8'h00, pa_oe}, 16'h0000);
            end else if (!wr) begin
                chk({mt, " released on read"}, {pa_oe, pb_oe}, 16'h0000);
            end else if (s16) begin
                chk("R5 wide write data", {pa_out, pb_out}, wd);
                chk("R5 wide write enables", {pa_oe, pb_oe}, 16'hFFFF);
            end else if (!ad[0]) begin
                chk("R6 even lane", {pa_out, pa_oe}, {wd[7:0], 8'hFF});
                chk("R6 odd port released", {8'h00, pb_oe}, 16'h0000);
            end else begin
                chk("R6 odd lane", {pb_out, pb_oe}, {wd[7:0], 8'hFF});
                chk("R6 even port released", {8'h00, pa_oe}, 16'h0000);
            end
        end
        @(negedge clk);
        chk("R10 ready after last data phase", {15'd0, req_ready}, 16'd1);
        chk("R3 rnw idle level", {15'd0, bus_rnw}, 16'd1);
        chk("R11 ports released when idle", {pa_oe, pb_oe}, 16'h0000);
        if (!wr)
            chk(nar ? (s16 ? "R8 read word" : "R9 read byte") : {mt, " read data"},
                rsp_rdata, exp_read(nar, s16, ad, a_rx[0], b_rx[0], a_rx[1]));
        req_valid = 1'b0;
        @(negedge clk);
        chk("R10 ready is one clock", {15'd0, req_ready}, 16'd0);
        chk("R3 no strobe after access", {15'd0, bus_as}, 16'd0);
    endtask

    task automatic gp_write(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk);
        gp_we = 1'b1; gp_sel = s; gp_wdata = v;
        @(negedge clk);
        gp_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_use;
        seed_use = $urandom(32'd20240611);

        // single-chip mode, then mode_sel moved to wide (must be ignored, R1)
        do_reset(2'b00, 2'b11);
        chk("R2 reset: enables off", {pa_oe, pb_oe}, 16'h0000);
        chk("R2 reset: outputs zero", {pa_out, pb_out}, 16'h0000);
        chk("R10 reset: no ready", {15'd0, req_ready}, 16'd0);
        chk("R3 reset: rnw high, no strobe", {14'd0, bus_rnw, bus_as}, 16'd2);
        gp_write(2'd0, 8'hA5);
        gp_write(2'd1, 8'h0F);
        gp_write(2'd2, 8'h3C);
        gp_write(2'd3, 8'hF0);
        chk("R2 data registers", {pa_out, pb_out}, 16'hA53C);
        chk("R2 direction registers", {pa_oe, pb_oe}, 16'h0FF0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_size16 = 1'b1;
        req_addr = 16'h1234; req_wdata = 16'hBEEF;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R2 request ignored: no strobe", {15'd0, bus_as}, 16'd0);
            chk("R2 request ignored: no ready", {15'd0, req_ready}, 16'd0);
            chk("R2 R1 ports stay as I/O", {pa_out, pb_out}, 16'hA53C);
        end
        req_valid = 1'b0;

        // narrow mode, then mode_sel moved to wide (R1)
        do_reset(2'b10, 2'b11);
        chk("R11 narrow idle released", {pa_oe, pb_oe}, 16'h0000);
        access(1, 1, 1, 16'h4000, 16'hCAFE);
        access(1, 0, 1, 16'h4000, 16'h0000);
        access(1, 0, 1, 16'hFFFF, 16'h0000);
        access(1, 1, 1, 16'hFFFF, 16'h1357);
        access(1, 1, 0, 16'h0101, 16'h00AB);
        access(1, 0, 0, 16'h0102, 16'h0000);
        for (int i = 0; i < 40; i++)
            access(1, 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom));

        // wide mode, then mode_sel moved to single (R1)
        do_reset(2'b11, 2'b00);
        chk("R11 wide idle released", {pa_oe, pb_oe}, 16'h0000);
        access(0, 1, 1, 16'h8001, 16'h1234);
        access(0, 0, 1, 16'h8001, 16'h0000);
        access(0, 1, 0, 16'h2000, 16'h0077);
        access(0, 1, 0, 16'h2001, 16'h0088);
        access(0, 0, 0, 16'h2000, 16'h0000);
        access(0, 0, 0, 16'h2001, 16'h0000);
        for (int i = 0; i < 40; i++)
            access(0, 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule